// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers single-cycle event pulses from the functions around it: forced wake-up, LIN fault or LIN wake-up, three supply and regulator monitor events, over-temperature on the high-side and low-side drivers, and pin wake-up. Each event sets its own pending flag. A group mask register, written over a small strobe bus, decides which groups may pull the active-low interrupt line. The host reads a 4-bit source code that names the highest-priority pending source. That read also acknowledges the source it names.

When other sources are still pending after an acknowledge, the interrupt line is not held low without a break. It is released for a fixed interval of about 10 µs, counted in clock cycles from the clock frequency parameter, and then pulled low again. The host sees a fresh falling edge for each remaining source. The bus has no back-pressure: every strobe completes in the cycle it is given, and read data appears on the next cycle. The event inputs are plain pulses and have no handshake.

Top module: `irq_ctrl`

## Requirements
- R1: After reset all four mask bits are 1, no flag is pending, `irq_n` is 1, and a source read returns 0000.
- R2: An event pulse sets its pending flag at the next clock edge. If the source is enabled, `irq_n` is 0 from that edge on.
- R3: A bus write to address 0 loads the mask from `bus_wdata`: bit 3 high-side, bit 2 low-side, bit 1 LIN, bit 0 voltage monitor, with 1 enabling the group. A masked source still sets its flag and is still reported, but it does not drive `irq_n` low.
- R4: Forced wake-up, pin wake-up, supply under-voltage and regulator over-temperature prewarning ignore the mask and always drive `irq_n` low.
- R5: The voltage-monitor mask bit gates only the supply over-voltage event.
- R6: A write to address 0 places the current source code on `bus_rdata` in the following cycle.
- R7: A read of address 1 returns the code of the highest-priority pending source. Codes, highest priority first: forced wake-up 0001, LIN 0010, voltage monitor 0011, high-side 0100, low-side 0101, pin wake-up 0110, none 0000.
- R8: A read of address 1 clears only the flags of the reported source; the voltage-monitor code clears all three of its events. A read of address 0 returns 0000 and acknowledges nothing.
- R9: After an acknowledge, `irq_n` stays 1 for HOLD_CYC cycles (CLK_HZ/1e6 × 10). If an enabled source is then pending, `irq_n` goes to 0; if none is pending, it stays 1.
- R10: An event that arrives during the release interval is latched and is reported once the interval ends.
- R11: An event that arrives in the same cycle as the acknowledge of its own source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | 0 selects the mask, 1 selects the source code |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, valid in the cycle after the strobe |
| ev_force_wake | input | 1 | Forced wake-up pulse |
| ev_lin | input | 1 | LIN fault or LIN wake-up pulse |
| ev_sup_ov | input | 1 | Supply over-voltage pulse |
| ev_sup_uv | input | 1 | Supply under-voltage pulse |
| ev_reg_otw | input | 1 | Regulator over-temperature prewarning pulse |
| ev_hs_ot | input | 1 | High-side over-temperature pulse |
| ev_ls_ot | input | 1 | Low-side over-temperature pulse |
| ev_pin_wake | input | 1 | Pin wake-up pulse |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Two functions can fall in the same cycle, and the bench drives both on purpose. The first is an acknowledging read together with a new pulse of the very source being acknowledged. The read is judged correct when it returns that source's code and a second read, made after the release interval, returns the same code again. The second is a new event arriving during the release interval. Here `irq_n` is sampled to stay high until the counted interval ends and to fall on the exact cycle it expires, and the next read must report the late event at its proper priority.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int NFLAG  = 7;
  localparam int NGRP   = 6;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    SRC_NONE  = 4'd0,
    SRC_FWAKE = 4'd1,
    SRC_LIN   = 4'd2,
    SRC_VMON  = 4'd3,
    SRC_HS    = 4'd4,
    SRC_LS    = 4'd5,
    SRC_PIN   = 4'd6
  } src_code_e;

  // pending flag slots
  localparam int F_FWAKE = 0;
  localparam int F_LIN   = 1;
  localparam int F_VM_OV = 2;
  localparam int F_VM_NM = 3;  // under-voltage or regulator prewarning
  localparam int F_HS    = 4;
  localparam int F_LS    = 5;
  localparam int F_PIN   = 6;

  // mask register bit positions
  localparam int M_VM  = 0;
  localparam int M_LIN = 1;
  localparam int M_LS  = 2;
  localparam int M_HS  = 3;

  // expand a one-hot group grant into the flags that group owns
  function automatic logic [NFLAG-1:0] grp_to_flags(input logic [NGRP-1:0] g);
    logic [NFLAG-1:0] f;
    f          = '0;
    f[F_FWAKE] = g[0];
    f[F_LIN]   = g[1];
    f[F_VM_OV] = g[2];
    f[F_VM_NM] = g[2];
    f[F_HS]    = g[3];
    f[F_LS]    = g[4];
    f[F_PIN]   = g[5];
    return f;
  endfunction

endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;  // a new event wins over a clear
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end

    AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);  // R2
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);  // R8
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_ctrl_pkg::*;
#(
  parameter int NG = NGRP
) (
  input  logic [NG-1:0]     pend_i,
  output logic [CODE_W-1:0] code_o,
  output logic [NG-1:0]     grant_o
);

  // slot 0 is the highest priority; its code is slot index + 1
  always_comb begin
    code_o  = '0;
    grant_o = '0;
    for (int i = NG - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        code_o     = CODE_W'(i + 1);
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end

  always_comb begin
    assert ($onehot0(grant_o));  // R7
    assert ((code_o == '0) == (pend_i == '0));  // R7
  end

endmodule

// File: rtl/irq_hold_timer.sv
module irq_hold_timer #(
  parameter int HOLD_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);

  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start_i)    cnt <= CW'(HOLD_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  AST_HOLD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt == CW'(HOLD_CYC)));  // R9
  AST_HOLD_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i) |=> (cnt == $past(cnt) - 1'b1));  // R9

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int CLK_HZ  = 10_000_000,
  parameter int HOLD_US = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [CODE_W-1:0] bus_wdata,
  output logic [CODE_W-1:0] bus_rdata,
  input  logic              ev_force_wake,
  input  logic              ev_lin,
  input  logic              ev_sup_ov,
  input  logic              ev_sup_uv,
  input  logic              ev_reg_otw,
  input  logic              ev_hs_ot,
  input  logic              ev_ls_ot,
  input  logic              ev_pin_wake,
  output logic              irq_n
);

  localparam int   HOLD_CYC = (CLK_HZ / 1_000_000) * HOLD_US;
  localparam logic ADDR_MASK = 1'b0;
  localparam logic ADDR_SRC  = 1'b1;

  logic [CODE_W-1:0] mask_q;
  logic [NFLAG-1:0]  set_v, clr_v, flag_q, en_v;
  logic [NGRP-1:0]   grp_pend, grant;
  logic [CODE_W-1:0] code;
  logic              ack, req, hold_busy, mask_wr, src_rd;

  assign mask_wr = bus_wr && (bus_addr == ADDR_MASK);
  assign src_rd  = bus_rd && (bus_addr == ADDR_SRC);

  always_comb begin
    set_v          = '0;
    set_v[F_FWAKE] = ev_force_wake;
    set_v[F_LIN]   = ev_lin;
    set_v[F_VM_OV] = ev_sup_ov;
    set_v[F_VM_NM] = ev_sup_uv | ev_reg_otw;
    set_v[F_HS]    = ev_hs_ot;
    set_v[F_LS]    = ev_ls_ot;
    set_v[F_PIN]   = ev_pin_wake;
  end

  // which flags may pull the interrupt line
  always_comb begin
    en_v          = '1;
    en_v[F_LIN]   = mask_q[M_LIN];
    en_v[F_VM_OV] = mask_q[M_VM];
    en_v[F_HS]    = mask_q[M_HS];
    en_v[F_LS]    = mask_q[M_LS];
  end

  assign grp_pend = {flag_q[F_PIN], flag_q[F_LS], flag_q[F_HS],
                     flag_q[F_VM_OV] | flag_q[F_VM_NM],
                     flag_q[F_LIN], flag_q[F_FWAKE]};

  irq_prio_enc #(.NG(NGRP)) u_enc (
    .pend_i (grp_pend),
    .code_o (code),
    .grant_o(grant)
  );

  assign ack   = src_rd && (code != '0);
  assign clr_v = ack ? grp_to_flags(grant) : '0;

  irq_pending #(.N(NFLAG)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_v),
    .clr_i (clr_v),
    .flag_o(flag_q)
  );

  irq_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(ack),
    .busy_o (hold_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '1;
      bus_rdata <= '0;
    end else begin
      if (mask_wr) mask_q <= bus_wdata;
      if (mask_wr || src_rd) bus_rdata <= code;
      else if (bus_rd)       bus_rdata <= '0;
    end
  end

  assign req   = |(flag_q & en_v);
  assign irq_n = ~(req & ~hold_busy);

  AST_NO_SRC_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |-> irq_n);  // R2
  AST_UV_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sup_uv |=> (!irq_n || hold_busy));  // R4
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> irq_n);  // R9
  AST_WR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (bus_rdata == $past(code)));  // R6

endmodule

// File: tb/irq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_ctrl_tb;

  localparam int CLK_PERIOD = 100;
  localparam int CLK_HZ     = 10_000_000;
  localparam int HOLD_CYC   = (CLK_HZ / 1_000_000) * 10;

  // event vector bits: 0 fwake,1 lin,2 ov,3 uv,4 otw,5 hs,6 ls,7 pin
  localparam logic [7:0] E_FW = 8'h01, E_LIN = 8'h02, E_OV = 8'h04, E_UV = 8'h08,
                         E_OTW = 8'h10, E_HS = 8'h20, E_LS = 8'h40, E_PIN = 8'h80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [3:0] bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic [7:0] ev = '0;
  logic       irq_n;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_force_wake(ev[0]), .ev_lin(ev[1]), .ev_sup_ov(ev[2]),
    .ev_sup_uv(ev[3]), .ev_reg_otw(ev[4]), .ev_hs_ot(ev[5]),
    .ev_ls_ot(ev[6]), .ev_pin_wake(ev[7]), .irq_n(irq_n)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] v);
    ev = v; tick(); ev = '0;
  endtask

  task automatic rd(input logic a, input logic [7:0] same, output logic [3:0] d);
    bus_rd = 1'b1; bus_addr = a; ev = same;
    tick();
    bus_rd = 1'b0; ev = '0; d = bus_rdata;
  endtask

  task automatic wr_mask(input logic [3:0] m);
    bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = m;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic wait_hold();
    repeat (HOLD_CYC + 1) tick();
  endtask

  task automatic t_reset();
    logic [3:0] d;
    chk("R1 irq_n after reset", irq_n, 1);
    rd(1'b1, '0, d);
    chk("R1 source after reset", d, 0);
  endtask

  task automatic t_single();
    logic [3:0] d;
    pulse(E_HS);
    chk("R2 irq_n low after hs", irq_n, 0);
    rd(1'b1, '0, d);
    chk("R7 hs code", d, 4);
    chk("R9 irq_n released", irq_n, 1);
    wait_hold();
    chk("R9 no re-assert when empty", irq_n, 1);
  endtask

  task automatic t_priority();
    logic [3:0] d;
    pulse(E_LIN | E_LS | E_PIN);
    chk("R2 irq_n low", irq_n, 0);
    rd(1'b0, '0, d);
    chk("R8 read addr 0 returns 0", d, 0);
    chk("R8 read addr 0 no ack", irq_n, 0);
    rd(1'b1, '0, d);
    chk("R7 lin first", d, 2);
    repeat (HOLD_CYC - 1) tick();
    chk("R9 high at end of hold", irq_n, 1);
    tick();
    chk("R9 low after hold", irq_n, 0);
    rd(1'b1, '0, d);
    chk("R7 ls second", d, 5);
    wait_hold();
    rd(1'b1, '0, d);
    chk("R7 pin third", d, 6);
    wait_hold();
    chk("R8 all cleared irq_n", irq_n, 1);
    rd(1'b1, '0, d);
    chk("R8 all cleared code", d, 0);
  endtask

  task automatic t_mask();
    logic [3:0] d;
    pulse(E_HS);
    wr_mask(4'b0000);
    chk("R6 write returns code", bus_rdata, 4);
    chk("R3 masked hs no irq", irq_n, 1);
    wr_mask(4'b1111);
    chk("R3 unmask restores irq", irq_n, 0);
    rd(1'b1, '0, d);
    chk("R3 hs flag kept", d, 4);
    wait_hold();
    wr_mask(4'b0111);  // bit 3 high-side off
    pulse(E_HS);
    chk("R3 hs bit masks", irq_n, 1);
    pulse(E_LS);
    chk("R3 ls still enabled", irq_n, 0);
    rd(1'b1, '0, d);
    chk("R7 hs before ls even masked", d, 4);
    wait_hold();
    rd(1'b1, '0, d);
    chk("R7 ls next", d, 5);
    wait_hold();
    wr_mask(4'b1111);
  endtask

  task automatic t_unmaskable();
    logic [3:0] d;
    wr_mask(4'b0000);
    pulse(E_OV);
    chk("R5 ov masked", irq_n, 1);
    rd(1'b1, '0, d);
    chk("R5 ov reported", d, 3);
    wait_hold();
    pulse(E_UV);
    chk("R4 uv unmaskable", irq_n, 0);
    rd(1'b1, '0, d);
    chk("R4 uv code", d, 3);
    wait_hold();
    pulse(E_OTW);
    chk("R4 otw unmaskable", irq_n, 0);
    rd(1'b1, '0, d); wait_hold();
    pulse(E_FW);
    chk("R4 fwake unmaskable", irq_n, 0);
    rd(1'b1, '0, d);
    chk("R7 fwake code", d, 1);
    wait_hold();
    pulse(E_PIN);
    chk("R4 pin unmaskable", irq_n, 0);
    rd(1'b1, '0, d); wait_hold();
    wr_mask(4'b1110);  // only voltage-monitor bit off
    pulse(E_LIN);
    chk("R5 vm bit leaves lin", irq_n, 0);
    rd(1'b1, '0, d); wait_hold();
    wr_mask(4'b1111);
    pulse(E_OV);
    chk("R5 ov enabled", irq_n, 0);
    pulse(E_UV);
    rd(1'b1, '0, d);
    chk("R8 vm code", d, 3);
    wait_hold();
    chk("R8 vm ack clears all vm", irq_n, 1);
  endtask

  task automatic t_late_event();
    logic [3:0] d;
    pulse(E_HS | E_LS);
    rd(1'b1, '0, d);
    chk("R7 hs over ls", d, 4);
    repeat (10) tick();
    pulse(E_LIN);
    chk("R10 held during hold", irq_n, 1);
    repeat (HOLD_CYC - 12) tick();
    chk("R10 still held", irq_n, 1);
    tick();
    chk("R10 asserted after hold", irq_n, 0);
    rd(1'b1, '0, d);
    chk("R10 late lin reported", d, 2);
    wait_hold();
    rd(1'b1, '0, d);
    chk("R10 ls kept", d, 5);
    wait_hold();
  endtask

  task automatic t_same_cycle();
    logic [3:0] d;
    pulse(E_HS);
    rd(1'b1, E_HS, d);
    chk("R11 ack code", d, 4);
    chk("R11 released", irq_n, 1);
    wait_hold();
    chk("R11 re-asserted", irq_n, 0);
    rd(1'b1, '0, d);
    chk("R11 still pending", d, 4);
    wait_hold();
    chk("R11 cleared", irq_n, 1);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_priority();
    t_mask();
    t_unmaskable();
    t_late_event();
    t_same_cycle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule